// File: doc/BRIEF.md
# USB Device Control/Status and Interrupt Register Block

This block holds the device-level control state of a USB device controller and turns hardware events into one interrupt line. Software reaches three 32-bit words over a simple register bus: a combined control/status word, an interrupt status word and an interrupt enable word. Each write carries an operation code. It can be a plain write, a write-one-to-clear or a bit-set. This lets firmware change one field without a read-modify-write.

The control/status word mixes three kinds of bit. Some are writable control fields: the device address, the enable bit and the connect (pull-up) bit. Some are live levels: suspend and debounced VBUS. Some are sticky event flags: setup received, connect change, suspend change and bus-reset change. The sticky flags are set by single-cycle event pulses from the surrounding controller. They are cleared only where software writes a one. When a change flag rises, the device-status bit of the interrupt status word is raised. Endpoint completions and start-of-frame also land in that word. The interrupt line is high while any enabled status bit is set.

Top module: `usb_devctl_csr`

## Requirements
- R1: Under a synchronous active-high reset, every stored bit is cleared. The read data and the interrupt output read zero, except for the live level bits of the control/status word.
- R2: Word select 0 is the control/status word. In it, bits 6:0 are the device address, bit 7 is enable and bit 16 is connect. Op 0 (and the reserved op 3) loads these fields from the write data. Op 2 ORs them with the write data. Op 1 clears the fields where the write data has ones. Bits of other fields are left alone by every op.
- R3: Bit 8 of the control/status word is set by the setup-received event. It is cleared only by a write that has a one in bit 8, whatever the op.
- R4: Bit 17 shows the live suspend level and bit 28 the live VBUS level. Writes do not affect them.
- R5: Bits 24, 25 and 26 are sticky flags for connect change, suspend change and bus-reset change. Each is set by its event and cleared only by a write with a one in that bit.
- R6: A bus-reset event forces the address field to zero. This wins over a software write in the same cycle, and the same event sets bit 26.
- R7: Word select 1 is interrupt status. Bits 0 to N_EP-1 are set by the endpoint-done inputs and bit 30 by start-of-frame. Any write clears the bits where the write data has ones. Unimplemented bits read zero.
- R8: Bit 31 of interrupt status is set in the cycle any of the three change flags goes from 0 to 1. An event on a flag that is already set does not set it.
- R9: The interrupt output is high exactly when interrupt status AND interrupt enable is non-zero.
- R10: Word select 2 is interrupt enable, with the same op codes as R2, over bits 0 to N_EP-1, 30 and 31. Other bits read zero.
- R11: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R12: Read data is registered. It shows the word addressed in the previous cycle, as it stood before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Word select: 0 control/status, 1 interrupt status, 2 interrupt enable |
| bus_we | input | 1 | Write strobe |
| bus_op | input | 2 | Write operation: 0 write, 1 clear-where-one, 2 set-where-one, 3 as write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_setup | input | 1 | Setup packet received pulse |
| ev_conn_chg | input | 1 | Connect change pulse |
| ev_susp_chg | input | 1 | Suspend change pulse |
| susp_lvl | input | 1 | Live suspend level |
| vbus_lvl | input | 1 | Debounced VBUS level |
| ep_done | input | N_EP | Endpoint completion pulses |
| sof | input | 1 | Start-of-frame pulse |
| irq | output | 1 | Interrupt request |

## Verification
The control fields are driven with plain, set and clear operations using data that overlaps other fields. This shows whether an op leaks into neighbouring bits. The sticky flags receive events in several cases: alone, repeated while already set, against writes of zero, and against writes of one in the same cycle. This separates true set-priority from level tracking. It also shows whether the device-status interrupt follows the 0-to-1 transition or the flag level. Interrupt enables are swept across endpoint, frame and device-status bits. This shows that the interrupt line follows the masked status and not the raw status.

// File: rtl/usbdc_pkg.sv
package usbdc_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_RSVD  = 2'd3
  } bus_op_e;

  localparam int REG_W     = 32;
  localparam int ADDR_W    = 7;
  localparam int POS_EN    = 7;
  localparam int POS_SETUP = 8;
  localparam int POS_CONN  = 16;
  localparam int POS_SUSP  = 17;
  localparam int POS_CCHG  = 24;
  localparam int POS_SCHG  = 25;
  localparam int POS_RCHG  = 26;
  localparam int POS_VBUS  = 28;
  localparam int POS_SOF   = 30;
  localparam int POS_DEV   = 31;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_IST = 2'd1;
  localparam logic [1:0] SEL_IEN = 2'd2;
endpackage

// File: rtl/usbdc_rw_reg.sv
module usbdc_rw_reg
  import usbdc_pkg::*;
#(
  parameter int         W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [1:0]   op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] wm;
  logic [W-1:0] nxt;

  assign wm = wdata & MASK;

  always_comb begin
    nxt = q;
    if (we) begin
      case (bus_op_e'(op))
        OP_SET:   nxt = q | wm;
        OP_CLEAR: nxt = q & ~wm;
        default:  nxt = wm;
      endcase
    end
    nxt = nxt & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_clr != '0) |=> ((q & $past(hw_clr)) == '0)); // R6
endmodule

// File: rtl/usbdc_flag_reg.sv
module usbdc_flag_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R11
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> ((q & $past(q)) == $past(q))); // R5
endmodule

// File: rtl/usb_devctl_csr.sv
module usb_devctl_csr
  import usbdc_pkg::*;
#(
  parameter int N_EP = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_sel,
  input  logic            bus_we,
  input  logic [1:0]      bus_op,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            ev_bus_reset,
  input  logic            ev_setup,
  input  logic            ev_conn_chg,
  input  logic            ev_susp_chg,
  input  logic            susp_lvl,
  input  logic            vbus_lvl,
  input  logic [N_EP-1:0] ep_done,
  input  logic            sof,
  output logic            irq
);
  localparam logic [REG_W-1:0] ADDR_MASK = (REG_W'(1) << ADDR_W) - REG_W'(1);
  localparam logic [REG_W-1:0] CTL_MASK  = ADDR_MASK | (REG_W'(1) << POS_EN)
                                         | (REG_W'(1) << POS_CONN);
  localparam logic [REG_W-1:0] EP_MASK   = (REG_W'(1) << N_EP) - REG_W'(1);
  localparam logic [REG_W-1:0] INT_MASK  = EP_MASK | (REG_W'(1) << POS_SOF)
                                         | (REG_W'(1) << POS_DEV);

  logic             ctl_wr, ist_wr, ien_wr;
  logic [REG_W-1:0] ctl_q, ien_q, ist_q;
  logic [REG_W-1:0] ctl_hw_clr, ist_set, ist_clr, ctl_rd;
  logic [3:0]       fl_set, fl_clr, fl_q;  // 0 setup, 1 conn chg, 2 susp chg, 3 reset chg
  logic             chg_rise;

  assign ctl_wr = bus_we && (bus_sel == SEL_CTL);
  assign ist_wr = bus_we && (bus_sel == SEL_IST);
  assign ien_wr = bus_we && (bus_sel == SEL_IEN);

  assign ctl_hw_clr = ev_bus_reset ? ADDR_MASK : '0;

  usbdc_rw_reg #(.W(REG_W), .MASK(CTL_MASK)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_wr), .op(bus_op), .wdata(bus_wdata),
    .hw_clr(ctl_hw_clr), .q(ctl_q)
  );

  usbdc_rw_reg #(.W(REG_W), .MASK(INT_MASK)) u_ien (
    .clk(clk), .rst(rst), .we(ien_wr), .op(bus_op), .wdata(bus_wdata),
    .hw_clr('0), .q(ien_q)
  );

  assign fl_set = {ev_bus_reset, ev_susp_chg, ev_conn_chg, ev_setup};
  assign fl_clr = ctl_wr ? {bus_wdata[POS_RCHG], bus_wdata[POS_SCHG],
                            bus_wdata[POS_CCHG], bus_wdata[POS_SETUP]} : 4'b0;

  usbdc_flag_reg #(.W(4)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr), .q(fl_q)
  );

  assign chg_rise = |(fl_set[3:1] & ~fl_q[3:1]);

  always_comb begin
    ist_set          = REG_W'(ep_done) & EP_MASK;
    ist_set[POS_SOF] = sof;
    ist_set[POS_DEV] = chg_rise;
  end
  assign ist_clr = ist_wr ? (bus_wdata & INT_MASK) : '0;

  usbdc_flag_reg #(.W(REG_W)) u_ist (
    .clk(clk), .rst(rst), .set(ist_set), .clr(ist_clr), .q(ist_q)
  );

  always_comb begin
    ctl_rd            = ctl_q;
    ctl_rd[POS_SETUP] = fl_q[0];
    ctl_rd[POS_CCHG]  = fl_q[1];
    ctl_rd[POS_SCHG]  = fl_q[2];
    ctl_rd[POS_RCHG]  = fl_q[3];
    ctl_rd[POS_SUSP]  = susp_lvl;
    ctl_rd[POS_VBUS]  = vbus_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_sel)
        SEL_CTL: bus_rdata <= ctl_rd;
        SEL_IST: bus_rdata <= ist_q;
        SEL_IEN: bus_rdata <= ien_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq = |(ist_q & ien_q);

  AST_RESET_ADDR: assert property (@(posedge clk) disable iff (rst)
    ev_bus_reset |=> (ctl_q[ADDR_W-1:0] == '0)); // R6
  AST_RESET_FLAG: assert property (@(posedge clk) disable iff (rst)
    ev_bus_reset |=> fl_q[3]); // R6
  AST_DEV_STATUS: assert property (@(posedge clk) disable iff (rst)
    (ev_conn_chg && !fl_q[1]) |=> ist_q[POS_DEV]); // R8
  AST_SOF_LATCH: assert property (@(posedge clk) disable iff (rst)
    sof |=> ist_q[POS_SOF]); // R7
endmodule

// File: tb/test_usb_devctl_csr.sv
`timescale 1ns/1ps
module test_usb_devctl_csr;
  localparam int NEP = 10;
  localparam logic [31:0] EPM  = (32'h1 << NEP) - 32'h1;
  localparam logic [31:0] IMPL = EPM | 32'hC000_0000;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] bus_sel, bus_op;
  logic bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic ev_bus_reset, ev_setup, ev_conn_chg, ev_susp_chg, susp_lvl, vbus_lvl, sof, irq;
  logic [NEP-1:0] ep_done;

  always #2.5 clk = ~clk;

  usb_devctl_csr #(.N_EP(NEP)) i_usb_devctl_csr (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_op(bus_op),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_bus_reset(ev_bus_reset),
    .ev_setup(ev_setup), .ev_conn_chg(ev_conn_chg), .ev_susp_chg(ev_susp_chg),
    .susp_lvl(susp_lvl), .vbus_lvl(vbus_lvl), .ep_done(ep_done), .sof(sof), .irq(irq)
  );

  // reference model state
  int unsigned m_addr;
  bit m_en, m_conn, m_setup, m_cc, m_sc, m_rc, m_irq;
  logic [31:0] m_ist, m_ien, m_rdata;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  function automatic logic [31:0] apply_op(logic [31:0] old, logic [31:0] d, logic [1:0] op);
    if (op == 2'd2) return old | d;
    if (op == 2'd1) return old & ~d;
    return d;
  endfunction

  function automatic logic [31:0] ctl_word();
    logic [31:0] w = '0;
    w[6:0] = m_addr[6:0]; w[7] = m_en; w[8] = m_setup; w[16] = m_conn;
    w[17] = susp_lvl; w[24] = m_cc; w[25] = m_sc; w[26] = m_rc; w[28] = vbus_lvl;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_en = 0; m_conn = 0; m_setup = 0; m_cc = 0; m_sc = 0; m_rc = 0;
      m_ist = '0; m_ien = '0; m_rdata = '0; m_irq = 0;
    end else begin
      bit rise;
      logic [31:0] t;
      case (bus_sel)
        2'd0: m_rdata = ctl_word();
        2'd1: m_rdata = m_ist;
        2'd2: m_rdata = m_ien;
        default: m_rdata = '0;
      endcase
      rise = (ev_conn_chg && !m_cc) || (ev_susp_chg && !m_sc) || (ev_bus_reset && !m_rc);
      if (bus_we && bus_sel == 2'd0) begin
        t = apply_op({15'b0, m_conn, 8'b0, m_en, m_addr[6:0]}, bus_wdata & 32'h0001_00FF, bus_op);
        m_addr = t[6:0]; m_en = t[7]; m_conn = t[16];
        if (bus_wdata[8])  m_setup = 0;
        if (bus_wdata[24]) m_cc = 0;
        if (bus_wdata[25]) m_sc = 0;
        if (bus_wdata[26]) m_rc = 0;
      end
      if (ev_bus_reset) begin m_addr = 0; m_rc = 1; end
      if (ev_setup) m_setup = 1;
      if (ev_conn_chg) m_cc = 1;
      if (ev_susp_chg) m_sc = 1;
      if (bus_we && bus_sel == 2'd1) m_ist = m_ist & ~(bus_wdata & IMPL);
      m_ist = m_ist | (32'(ep_done) & EPM) | (32'(sof) << 30) | (32'(rise) << 31);
      if (bus_we && bus_sel == 2'd2) m_ien = apply_op(m_ien, bus_wdata & IMPL, bus_op);
    end
    m_irq = |(m_ist & m_ien);
  end

  task automatic compare();
    compared++;
    if (bus_rdata !== m_rdata) begin
      mismatched++;
      $display("FAIL %s rdata actual %h expected %h", cur_req, bus_rdata, m_rdata);
    end
    compared++;
    if (irq !== m_irq) begin
      mismatched++;
      $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_irq);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    compare();
    bus_we = 0; ev_bus_reset = 0; ev_setup = 0; ev_conn_chg = 0; ev_susp_chg = 0;
    sof = 0; ep_done = '0;
  endtask

  task automatic wr(logic [1:0] s, logic [1:0] op, logic [31:0] d);
    bus_sel = s; bus_op = op; bus_wdata = d; bus_we = 1; cyc();
  endtask

  task automatic rd_all();
    for (int s = 0; s < 3; s++) begin bus_sel = 2'(s); cyc(); end
    bus_sel = 2'd0; cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_sel = 0; bus_we = 0; bus_op = 0; bus_wdata = 0;
    ev_bus_reset = 0; ev_setup = 0; ev_conn_chg = 0; ev_susp_chg = 0;
    susp_lvl = 0; vbus_lvl = 1; sof = 0; ep_done = '0;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    cur_req = "R1"; rd_all();

    cur_req = "R2"; // write, set, clear, reserved op on control fields
    wr(0, 0, 32'h0001_00B5); rd_all();
    wr(0, 2, 32'h0000_0040); rd_all();
    wr(0, 1, 32'h0001_0001); rd_all();
    wr(0, 3, 32'hFFFE_FF2A); rd_all();

    cur_req = "R4"; // live levels, writes ignored
    susp_lvl = 1; vbus_lvl = 0; rd_all();
    wr(0, 0, 32'h1002_0000); rd_all();
    susp_lvl = 0; vbus_lvl = 1; rd_all();

    cur_req = "R3"; // setup flag
    ev_setup = 1; cyc(); rd_all();
    wr(0, 2, 32'h0000_0000); wr(0, 1, 32'h0000_0000); rd_all();
    wr(0, 2, 32'h0000_0100); rd_all();

    cur_req = "R5"; // change flags
    ev_conn_chg = 1; cyc(); ev_susp_chg = 1; cyc(); rd_all();
    wr(0, 0, 32'h0000_0000); rd_all();
    wr(0, 1, 32'h0100_0000); rd_all();
    wr(0, 1, 32'h0200_0000); rd_all();

    cur_req = "R6"; // bus reset
    wr(0, 0, 32'h0000_007F); ev_bus_reset = 1; cyc(); rd_all();
    ev_bus_reset = 1; bus_sel = 0; bus_op = 0; bus_wdata = 32'h0000_0055; bus_we = 1; cyc(); rd_all();

    cur_req = "R8"; // device status from change rise
    wr(1, 0, 32'hFFFF_FFFF); rd_all();
    ev_conn_chg = 1; cyc(); rd_all();
    wr(1, 1, 32'h8000_0000); rd_all();
    ev_conn_chg = 1; cyc(); rd_all();
    ev_bus_reset = 1; cyc(); rd_all();
    wr(0, 1, 32'h0700_0000); ev_susp_chg = 1; cyc(); rd_all();

    cur_req = "R7"; // endpoint and frame status
    wr(1, 0, 32'hFFFF_FFFF);
    ep_done = 10'h201; cyc(); sof = 1; cyc(); ep_done = 10'h0F0; cyc(); rd_all();
    wr(1, 2, 32'h3FFF_FC00); rd_all();
    wr(1, 0, 32'h4000_0011); rd_all();

    cur_req = "R10"; // enable register ops
    wr(2, 0, 32'hFFFF_FFFF); rd_all();
    wr(2, 1, 32'h3FFF_FFFE); rd_all();
    wr(2, 2, 32'h0000_0300); rd_all();

    cur_req = "R9"; // masked interrupt
    wr(2, 0, 32'h0000_0000); wr(1, 0, 32'hFFFF_FFFF); rd_all();
    ep_done = 10'h004; cyc(); rd_all();
    wr(2, 2, 32'h0000_0004); rd_all();
    wr(1, 0, 32'h0000_0004); rd_all();
    wr(2, 0, 32'h8000_0000); ev_susp_chg = 1; cyc(); rd_all();
    wr(0, 1, 32'h0200_0000); wr(1, 0, 32'h8000_0000); rd_all();
    wr(2, 0, 32'h4000_0000); sof = 1; cyc(); rd_all();

    cur_req = "R11"; // set beats clear
    ev_setup = 1; wr(0, 0, 32'h0000_0100); rd_all();
    ep_done = 10'h008; wr(1, 0, 32'h0000_0008); rd_all();
    ev_conn_chg = 1; wr(0, 1, 32'h0100_0000); rd_all();

    cur_req = "R12"; // registered read of pre-write value
    wr(2, 0, 32'h0000_00AA); wr(2, 0, 32'h0000_0055); bus_sel = 2; cyc();
    bus_sel = 3; cyc(); cyc();

    cur_req = "R1";
    rst = 1; cyc(); cyc(); rst = 0; rd_all();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule